// File: doc/BRIEF.md
# Parallel-Priority Bus Acquisition Controller

This block lets one master win, hold and give up a bus that several masters share. An external encoder resolves priority in parallel. A local agent raises a transfer request, and the block turns it into an active-low bus request. It then waits until its priority input says that no higher-ranked master wants the bus and until the shared busy line is free. At that point it pulls the busy line low and enables its address and command drivers.

Ownership lasts across any number of back-to-back transfers while the request and priority stay asserted. When priority is withdrawn or the local request ends, the block first waits for the running command to finish. It then frees the busy line and switches its drivers off in the same step. For daisy-chained systems it also produces a priority output for the next master down the chain.

Every decision is taken only when the bus clock falls. The block runs on a fast core clock, and the bus clock arrives as a level that is synchronous to that core clock. A falling-edge detector turns each high-to-low transition into a one-cycle enable, and all state advances only on that enable. An active-low bus initialisation input forces the idle state.

Top module: `bus_master_arb`

## Requirements
- R1: Between falling edges of `bclk`, none of the four outputs changes. The only exceptions are initialisation and reset.
- R2: `breq_n` is low exactly when `xfer_req` was high at the most recent falling edge of `bclk`.
- R3: A master that is not owning the bus takes it at a falling edge when all three hold at that edge: `breq_n` is already low, `prio_in_n` is low and `busy_in_n` is high. Taking the bus drives `busy_out_n` and `drv_en_n` low. The minimum latency from the request is therefore two falling edges.
- R4: While `busy_in_n` is held low by another master, the block never takes the bus.
- R5: An owner gives up the bus at a falling edge when `cmd_active` is low and either `prio_in_n` is high or `breq_n` is high.
- R6: While `cmd_active` is high, an owner never gives up the bus.
- R7: `drv_en_n` and `busy_out_n` are asserted and negated together.
- R8: At each falling edge, `prio_out_n` is updated. It goes low exactly when `prio_in_n` is low and `xfer_req` is low at that edge.
- R9: If `init_n` is low at a core-clock edge, all four outputs are high after that edge. `init_n` takes effect whatever `bclk` is doing.
- R10: While `rst_n` is low, all four outputs are high at once.
- R11: While the request and the priority stay asserted, an owner keeps the bus over any number of falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| init_n | input | 1 | Active-low bus initialisation, synchronous clear |
| bclk | input | 1 | Bus clock level, synchronous to `clk` |
| xfer_req | input | 1 | Local agent wants the bus |
| cmd_active | input | 1 | A local bus command is still in progress |
| prio_in_n | input | 1 | Low: no higher-priority master is requesting |
| busy_in_n | input | 1 | Observed shared busy line, low when any master owns the bus |
| breq_n | output | 1 | Bus request, active low |
| busy_out_n | output | 1 | This master's open-collector busy drive, low while it owns the bus |
| drv_en_n | output | 1 | Address and command driver enable, active low |
| prio_out_n | output | 1 | Priority passed to the next lower master, active low |

## Verification
The bench moves inputs in the middle of a bus-clock phase. A design that reacted to the core clock rather than the falling bus edge would move `breq_n` early. It drops priority while a command is still running; a design that ignored `cmd_active` would free the busy line in the middle of a transfer. It holds the shared busy line low from outside while priority and request are present, so a design that did not watch busy would collide with the other master. It also drops the local request, which must cost exactly one extra edge, applies `init_n` and asynchronous reset while the bus is owned, and walks `prio_out_n` through request and no-request cases.

// File: rtl/bus_master_arb_pkg.sv
package bus_master_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_OWN  = 1'b1
  } arb_state_e;
endpackage

// File: rtl/bclk_fall_det.sv
module bclk_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  output logic fall
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = bclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign fall = prev_q & ~bclk;
endmodule

// File: rtl/arb_req_stage.sv
module arb_req_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic init_n,
  input  logic tick,
  input  logic xfer_req,
  input  logic prio_in_n,
  output logic req_q,
  output logic pout_q
);
  logic req_d;
  logic pout_d;

  always_comb begin
    req_d  = req_q;
    pout_d = pout_q;
    if (!init_n) begin
      req_d  = 1'b0;
      pout_d = 1'b0;
    end else if (tick) begin
      req_d  = xfer_req;
      pout_d = ~prio_in_n & ~xfer_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pout_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      pout_q <= pout_d;
    end
  end
endmodule

// File: rtl/arb_own_fsm.sv
module arb_own_fsm
  import bus_master_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_n,
  input  logic tick,
  input  logic req_q,
  input  logic prio_in_n,
  input  logic busy_in_n,
  input  logic cmd_active,
  output logic own
);
  arb_state_e state_q;
  arb_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!init_n) begin
      state_d = ARB_IDLE;
    end else if (tick) begin
      unique case (state_q)
        ARB_IDLE: if (req_q && !prio_in_n && busy_in_n) state_d = ARB_OWN;
        ARB_OWN:  if ((prio_in_n || !req_q) && !cmd_active) state_d = ARB_IDLE;
        default:  state_d = ARB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  assign own = (state_q == ARB_OWN);
endmodule

// File: rtl/bus_master_arb.sv
module bus_master_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic init_n,
  input  logic bclk,
  input  logic xfer_req,
  input  logic cmd_active,
  input  logic prio_in_n,
  input  logic busy_in_n,
  output logic breq_n,
  output logic busy_out_n,
  output logic drv_en_n,
  output logic prio_out_n
);
  logic tick;
  logic req_q;
  logic pout_q;
  logic own;

  bclk_fall_det u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .bclk  (bclk),
    .fall  (tick)
  );

  arb_req_stage u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_n    (init_n),
    .tick      (tick),
    .xfer_req  (xfer_req),
    .prio_in_n (prio_in_n),
    .req_q     (req_q),
    .pout_q    (pout_q)
  );

  arb_own_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_n     (init_n),
    .tick       (tick),
    .req_q      (req_q),
    .prio_in_n  (prio_in_n),
    .busy_in_n  (busy_in_n),
    .cmd_active (cmd_active),
    .own        (own)
  );

  assign breq_n     = ~req_q;
  assign busy_out_n = ~own;
  assign drv_en_n   = ~own;
  assign prio_out_n = ~pout_q;
endmodule

// File: rtl/bus_master_arb_chk.sv
module bus_master_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic init_n,
  input logic bclk,
  input logic cmd_active,
  input logic prio_in_n,
  input logic busy_in_n,
  input logic breq_n,
  input logic busy_out_n,
  input logic drv_en_n,
  input logic prio_out_n
);
  logic bclk_seen;
  logic fell_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_seen <= 1'b0;
    else        bclk_seen <= bclk;
  end

  assign fell_now = bclk_seen & ~bclk;

  AST_QUIET_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (!fell_now && init_n) |=> $stable({breq_n, busy_out_n, drv_en_n, prio_out_n})); // R1

  AST_GRAB_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (fell_now && init_n && busy_out_n && !breq_n && !prio_in_n && busy_in_n) |=> !busy_out_n); // R3

  AST_NO_GRAB_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_out_n && !busy_in_n) |=> busy_out_n); // R4

  AST_HOLD_DURING_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_out_n && cmd_active && init_n) |=> !busy_out_n); // R6

  AST_DRV_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en_n == busy_out_n)); // R7

  AST_POUT_ONLY_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_out_n |-> breq_n); // R8

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |=> (breq_n && busy_out_n && drv_en_n && prio_out_n)); // R9
endmodule

bind bus_master_arb bus_master_arb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_n     (init_n),
  .bclk       (bclk),
  .cmd_active (cmd_active),
  .prio_in_n  (prio_in_n),
  .busy_in_n  (busy_in_n),
  .breq_n     (breq_n),
  .busy_out_n (busy_out_n),
  .drv_en_n   (drv_en_n),
  .prio_out_n (prio_out_n)
);

// File: tb/bus_master_arb_tb.sv
`timescale 1ns/1ps
module bus_master_arb_tb;
  logic clk = 1'b0;
  logic rst_n, init_n, bclk, xfer_req, cmd_active, prio_in_n, other_busy_n;
  logic busy_in_n, breq_n, busy_out_n, drv_en_n, prio_out_n;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  // reference state
  logic m_prev, m_req, m_own, m_pout;

  always #5 clk = ~clk;

  assign busy_in_n = busy_out_n & other_busy_n;

  bus_master_arb u_dut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .bclk(bclk),
    .xfer_req(xfer_req), .cmd_active(cmd_active), .prio_in_n(prio_in_n),
    .busy_in_n(busy_in_n), .breq_n(breq_n), .busy_out_n(busy_out_n),
    .drv_en_n(drv_en_n), .prio_out_n(prio_out_n)
  );

  // bus clock: toggles every 4 core cycles, 2 ns after the edge
  initial begin
    bclk = 1'b1;
    forever begin
      repeat (4) @(posedge clk);
      #2 bclk = ~bclk;
    end
  end

  // behavioural reference, advanced once per core clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev <= 1'b0; m_req <= 1'b0; m_own <= 1'b0; m_pout <= 1'b0;
    end else begin
      m_prev <= bclk;
      if (!init_n) begin
        m_req <= 1'b0; m_own <= 1'b0; m_pout <= 1'b0;
      end else if (m_prev && !bclk) begin
        m_req  <= xfer_req;
        m_pout <= !prio_in_n && !xfer_req;
        if (!m_own) m_own <= m_req && !prio_in_n && other_busy_n;
        else if ((prio_in_n || !m_req) && !cmd_active) m_own <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 breq_n vs model",      breq_n,     !m_req);
      chk("R3 busy_out_n vs model",  busy_out_n, !m_own);
      chk("R7 drv_en_n vs model",    drv_en_n,   !m_own);
      chk("R8 prio_out_n vs model",  prio_out_n, !m_pout);
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  // wait for a falling bus edge and the core edge that acts on it
  task automatic wait_fall();
    @(negedge bclk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, breq_n, 1'b1);
    chk(tag, busy_out_n, 1'b1);
    chk(tag, drv_en_n, 1'b1);
    chk(tag, prio_out_n, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; init_n = 1'b1; xfer_req = 1'b0; cmd_active = 1'b0;
    prio_in_n = 1'b1; other_busy_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R10 reset state");
    rst_n = 1'b1;

    // priority passes down when not requesting
    prio_in_n = 1'b0;
    wait_fall();
    chk("R8 pout low with prio and no req", prio_out_n, 1'b0);

    // request mid-phase: must wait for the next falling edge
    xfer_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 breq_n unchanged before edge", breq_n, 1'b1);
    wait_fall();
    chk("R2 breq_n asserted at edge", breq_n, 1'b0);
    chk("R8 pout negated while requesting", prio_out_n, 1'b1);
    chk("R3 no grab on sync edge", busy_out_n, 1'b1);
    wait_fall();
    chk("R3 grab on next edge", busy_out_n, 1'b0);
    chk("R7 drivers on with busy", drv_en_n, 1'b0);

    // back-to-back ownership
    wait_fall();
    wait_fall();
    chk("R11 still owning", busy_out_n, 1'b0);

    // priority withdrawn while command runs
    cmd_active = 1'b1; prio_in_n = 1'b1;
    wait_fall();
    chk("R6 hold during command", busy_out_n, 1'b0);
    cmd_active = 1'b0;
    wait_fall();
    chk("R5 release after command", busy_out_n, 1'b1);
    chk("R7 drivers off with busy", drv_en_n, 1'b1);

    // another master holds busy
    prio_in_n = 1'b0; other_busy_n = 1'b0;
    wait_fall();
    wait_fall();
    chk("R4 no grab while busy held", busy_out_n, 1'b1);
    other_busy_n = 1'b1;
    wait_fall();
    chk("R3 grab once busy free", busy_out_n, 1'b0);

    // local request dropped: one edge to sample, one to release
    xfer_req = 1'b0;
    wait_fall();
    chk("R5 hold while request sampling", busy_out_n, 1'b0);
    chk("R2 breq_n negated", breq_n, 1'b1);
    wait_fall();
    chk("R5 release after request drop", busy_out_n, 1'b1);

    // regain, then initialise
    xfer_req = 1'b1;
    wait_fall();
    wait_fall();
    chk("R3 regained", busy_out_n, 1'b0);
    init_n = 1'b0;
    @(negedge clk);
    chk_idle("R9 init clears");
    init_n = 1'b1;

    // regain, then asynchronous reset
    wait_fall();
    wait_fall();
    chk("R11 owner again", busy_out_n, 1'b0);
    rst_n = 1'b0;
    #1;
    chk_idle("R10 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    xfer_req = 1'b0;
    repeat (20) @(negedge clk);
    finish_up();
  end
endmodule